// File: doc/BRIEF.md
# Scanline Compare Interrupt Timer

This block counts video scanlines and raises an interrupt on a chosen line. A 10-bit line counter steps once on every horizontal-blank-start strobe and returns to zero on the vertical-blank-end strobe. Software writes a target line number into a write-only compare register. When the count reaches that number, the block sends a one-cycle interrupt pulse on the clock after the strobe that caused the match. A target of zero is a special case: the pulse follows the vertical-blank-start strobe instead of a counted line.

The block also drives a level `line_match` flag. A companion dot timer uses this flag to restrict its own interrupts to the selected line. The flag rises together with the interrupt and stays high until the next horizontal-blank strobe. All blanking strobes arrive already synchronised and last one clock.

A global enable gates the interrupt and the flag. It does not gate the counter, which keeps following the blanking strobes. The block has no data stream, so none of its pins use a valid/ready handshake. All pins are plain control or status signals, and the write port is a single-cycle strobe that is always accepted.

Top module: `scanline_irq_timer`

## Requirements
- R1: Each `hblank_in` strobe increments the line counter by one. The counter is observed through the interrupt: with target N, exactly the N-th strobe after a clear produces the pulse.
- R2: A `vblank_end` strobe clears the counter to zero. If it arrives in the same cycle as `hblank_in`, the clear wins and no match is taken.
- R3: With a nonzero target T, `irq` is high for exactly one cycle. That cycle is the one following the clock edge at which the `hblank_in` strobe brought the count to T.
- R4: With a target of 0, `irq` is high for one cycle, following the edge at which `vblank_out` was sampled. Counted lines then never match.
- R5: A target that the counter does not reach within a frame produces no pulse. An example is 500 with only 10 lines between clears.
- R6: The counter saturates at 1023 and does not wrap. A strobe that arrives while the counter is saturated produces no match.
- R7: `line_match` rises in the same cycle as `irq`. It stays high until the edge that samples the next `hblank_in`, where it falls unless that strobe is itself a match.
- R8: While `timer_en` is low, `irq` stays low and `line_match` is low from the next cycle on. The counter keeps counting and clearing.
- R9: A write with `wr_en` high and `wr_addr` equal to 0x90 loads `wr_data[9:0]` as the target, which takes effect from the next cycle. A write to any other address leaves the target unchanged. After reset, no interrupt is produced until the first target write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hblank_in | input | 1 | One-cycle horizontal-blank-start strobe |
| vblank_end | input | 1 | One-cycle vertical-blank-end strobe (counter clear) |
| vblank_out | input | 1 | One-cycle vertical-blank-start strobe |
| timer_en | input | 1 | Global timer enable |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register byte offset |
| wr_data | input | 32 | Register write data |
| irq | output | 1 | One-cycle interrupt pulse |
| line_match | output | 1 | Level flag, high on the selected line |

## Verification
Every result appears exactly one clock after the edge that samples its cause:
- A pulse from a matching `hblank_in` or `vblank_out` strobe appears one edge later.
- `line_match` rises and falls at that same edge.
- A loss of enable shows at the next edge.
- A target write affects only comparisons made after the edge that stores it.

The bench drives inputs a short delay after each rising edge and samples outputs on the falling edge. It advances its behavioural model on the rising edge, so each comparison sees the registered result of exactly the previous edge. Separate per-scenario pulse counts check the line-number outcomes against values worked out by hand.

// File: rtl/scanline_tmr_pkg.sv
package scanline_tmr_pkg;
  localparam int unsigned DEF_LINE_W = 10;
  localparam int unsigned DEF_ADDR_W = 8;
  localparam int unsigned DEF_DATA_W = 32;
  localparam logic [DEF_ADDR_W-1:0] DEF_CMP_ADDR = 8'h90;

  typedef struct packed {
    logic hblank;
    logic vend;
    logic vstart;
  } blank_strobes_t;
endpackage

// File: rtl/slt_line_counter.sv
module slt_line_counter #(
  parameter int unsigned LINE_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hblank,
  input  logic              vend,
  output logic [LINE_W-1:0] count,
  output logic [LINE_W-1:0] count_next,
  output logic              step
);
  localparam logic [LINE_W-1:0] CNT_MAX = {LINE_W{1'b1}};

  assign step       = hblank && !vend && (count != CNT_MAX);
  assign count_next = count + 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n)        count <= '0;
    else if (vend)     count <= '0;
    else if (step)     count <= count_next;
  end

  assert_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    vend |=> (count == '0));
  assert_incr_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (hblank && !vend && count != CNT_MAX) |=> (count == $past(count) + 1'b1));
  assert_saturate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (count == CNT_MAX && !vend) |=> (count == CNT_MAX));
endmodule

// File: rtl/slt_cmp_reg.sv
module slt_cmp_reg #(
  parameter int unsigned LINE_W = 10,
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32,
  parameter logic [ADDR_W-1:0] CMP_ADDR = 8'h90
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [LINE_W-1:0] target,
  output logic              target_valid
);
  logic hit;
  assign hit = wr_en && (wr_addr == CMP_ADDR);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      target       <= '0;
      target_valid <= 1'b0;
    end else if (hit) begin
      target       <= wr_data[LINE_W-1:0];
      target_valid <= 1'b1;
    end
  end

  assert_other_addr_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en || wr_addr != CMP_ADDR) |=> $stable(target));
endmodule

// File: rtl/slt_compare.sv
module slt_compare #(
  parameter int unsigned LINE_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              hblank,
  input  logic              vstart,
  input  logic              step,
  input  logic [LINE_W-1:0] count_next,
  input  logic [LINE_W-1:0] target,
  input  logic              target_valid,
  output logic              irq,
  output logic              line_match
);
  logic zero_tgt;
  logic hit_line;
  logic hit_zero;
  logic hit;

  assign zero_tgt = (target == '0);
  assign hit_line = step && target_valid && !zero_tgt && (count_next == target);
  assign hit_zero = vstart && target_valid && zero_tgt;
  assign hit      = hit_line || hit_zero;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq        <= 1'b0;
      line_match <= 1'b0;
    end else begin
      irq <= enable && hit;
      if (!enable)     line_match <= 1'b0;
      else if (hit)    line_match <= 1'b1;
      else if (hblank) line_match <= 1'b0;
    end
  end

  assert_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!irq && !line_match));
  assert_flag_with_irq_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> line_match);
  assert_flag_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (line_match && !hblank && enable) |=> line_match);
  assert_no_pulse_unwritten_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !target_valid |=> !irq);
endmodule

// File: rtl/scanline_irq_timer.sv
module scanline_irq_timer
  import scanline_tmr_pkg::*;
#(
  parameter int unsigned LINE_W = DEF_LINE_W,
  parameter int unsigned ADDR_W = DEF_ADDR_W,
  parameter int unsigned DATA_W = DEF_DATA_W,
  parameter logic [ADDR_W-1:0] CMP_ADDR = DEF_CMP_ADDR
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hblank_in,
  input  logic              vblank_end,
  input  logic              vblank_out,
  input  logic              timer_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              irq,
  output logic              line_match
);
  blank_strobes_t    strb;
  logic [LINE_W-1:0] count;
  logic [LINE_W-1:0] count_next;
  logic              step;
  logic [LINE_W-1:0] target;
  logic              target_valid;

  assign strb = '{hblank: hblank_in, vend: vblank_end, vstart: vblank_out};

  slt_line_counter #(.LINE_W(LINE_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .hblank(strb.hblank), .vend(strb.vend),
    .count(count), .count_next(count_next), .step(step)
  );

  slt_cmp_reg #(.LINE_W(LINE_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
                .CMP_ADDR(CMP_ADDR)) u_reg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .target(target), .target_valid(target_valid)
  );

  slt_compare #(.LINE_W(LINE_W)) u_cmp (
    .clk(clk), .rst_n(rst_n), .enable(timer_en), .hblank(strb.hblank),
    .vstart(strb.vstart), .step(step), .count_next(count_next),
    .target(target), .target_valid(target_valid),
    .irq(irq), .line_match(line_match)
  );

  assert_line_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !$past(vblank_out)) |-> $past(hblank_in && !vblank_end));
  assert_zero_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && target == '0 && !$past(wr_en)) |-> $past(vblank_out));
endmodule

// File: tb/scanline_irq_timer_tb_top.sv
`timescale 1ns/1ps
module scanline_irq_timer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hblank_in = 1'b0, vblank_end = 1'b0, vblank_out = 1'b0;
  logic        timer_en = 1'b0, wr_en = 1'b0;
  logic [7:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        irq, line_match;

  int n_checks = 0;
  int n_fail = 0;
  int irq_seen = 0;
  string phase = "R1";

  // behavioural model state
  int  m_cnt = 0, m_tgt = 0;
  bit  m_valid = 0, m_irq = 0, m_flag = 0;

  always #10 clk = ~clk;

  scanline_irq_timer dut_i (
    .clk(clk), .rst_n(rst_n), .hblank_in(hblank_in), .vblank_end(vblank_end),
    .vblank_out(vblank_out), .timer_en(timer_en), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .irq(irq), .line_match(line_match)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_valid = 0; m_irq = 0; m_flag = 0; m_tgt = 0;
    end else begin
      bit adv, hit;
      adv = hblank_in && !vblank_end && m_cnt < 1023;
      hit = (adv && m_valid && m_tgt != 0 && m_cnt + 1 == m_tgt) ||
            (vblank_out && m_valid && m_tgt == 0);
      m_irq = timer_en && hit;
      if (!timer_en) m_flag = 0;
      else if (hit) m_flag = 1;
      else if (hblank_in) m_flag = 0;
      if (vblank_end) m_cnt = 0;
      else if (adv) m_cnt = m_cnt + 1;
      if (wr_en && wr_addr == 8'h90) begin
        m_tgt = int'(wr_data[9:0]); m_valid = 1;
      end
    end
  end

  always @(negedge clk) begin
    n_checks++;
    if (irq !== m_irq || line_match !== m_flag) begin
      n_fail++;
      $display("FAIL %s: irq=%0b line_match=%0b expected irq=%0b line_match=%0b",
               phase, irq, line_match, m_irq, m_flag);
    end
    if (irq === 1'b1) irq_seen++;
  end

  task automatic drive(input bit h, input bit e, input bit o);
    @(posedge clk); #2;
    hblank_in = h; vblank_end = e; vblank_out = o;
  endtask

  task automatic idle(); drive(0, 0, 0); endtask

  task automatic lines(input int n);
    for (int i = 0; i < n; i++) begin drive(1, 0, 0); idle(); end
  endtask

  task automatic frame(input int n);
    drive(0, 1, 0); idle();
    lines(n);
    drive(0, 0, 1); idle();
  endtask

  task automatic wr(input logic [7:0] a, input int v);
    @(posedge clk); #2; wr_en = 1; wr_addr = a; wr_data = v;
    @(posedge clk); #2; wr_en = 0;
  endtask

  task automatic expect_pulses(input int exp, input string tag);
    idle(); idle();
    n_checks++;
    if (irq_seen != exp) begin
      n_fail++;
      $display("FAIL %s: pulses=%0d expected=%0d", tag, irq_seen, exp);
    end
    irq_seen = 0;
  endtask

  initial begin
    #200000000;
    n_fail++;
    $display("FAIL watchdog: run did not finish");
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1; timer_en = 1;
    @(negedge clk);
    n_checks++;
    if (irq !== 0 || line_match !== 0) begin
      n_fail++;
      $display("FAIL reset: irq=%0b line_match=%0b expected 0 0", irq, line_match);
    end
    irq_seen = 0;

    phase = "R9"; frame(6); frame(6); expect_pulses(0, "R9 unwritten");
    phase = "R3"; wr(8'h90, 3); frame(10); frame(10); expect_pulses(2, "R3 target 3");
    phase = "R1"; wr(8'h90, 10); frame(10); expect_pulses(1, "R1 tenth line");
    phase = "R7"; wr(8'h90, 1); frame(4); expect_pulses(1, "R7 first line");
    phase = "R4"; wr(8'h90, 0); frame(8); frame(8); expect_pulses(2, "R4 zero target");
    phase = "R5"; wr(8'h90, 500); frame(10); frame(10); expect_pulses(0, "R5 unreachable");
    phase = "R9"; wr(8'h90, 4); wr(8'h94, 2); frame(10); expect_pulses(1, "R9 other addr ignored");
    phase = "R2"; drive(0, 1, 0); idle(); lines(3); drive(1, 1, 0); idle(); lines(3);
    expect_pulses(0, "R2 clear wins");
    lines(1); expect_pulses(1, "R2 fourth after clear");
    phase = "R8"; timer_en = 0; frame(10); frame(10); expect_pulses(0, "R8 disabled");
    drive(0, 1, 0); idle(); lines(2); timer_en = 1; lines(4);
    expect_pulses(1, "R8 counter kept tracking");
    phase = "R6"; wr(8'h90, 1023); drive(0, 1, 0); idle(); lines(1100);
    expect_pulses(1, "R6 reaches max once");
    wr(8'h90, 5); lines(20); expect_pulses(0, "R6 no wrap");
    frame(6); expect_pulses(1, "R6 clear after saturation");

    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule